// File: doc/BRIEF.md
# Dual 24-bit Down-Counting Timer

This peripheral holds two identical down-counting timers behind a single-cycle 32-bit register port. Each timer has a control word, a reload value and a prescaler, and counts down from its reload value by one on every prescaled tick. When a count runs out, the timer sets its own bit in a shared event register. In single-shot mode the timer then stops by itself at zero. In repeating mode it reloads and keeps running. Each timer drives its own interrupt line.

Software arms a timer by writing its reload value and then setting the run bit. The rising edge of the run bit loads the counter. The second timer's live count can be read back at any time. Left running in repeating mode with the largest reload value, it serves as a free-running time base.

Reads are combinational from the address. A write takes effect on the clock edge that ends the cycle in which the write is presented.

Top module: `dual_dntimer`

## Requirements
- R1: After reset every register reads zero, both counters are stopped and both interrupt lines are low.
- R2: The byte offsets are fixed: 0x00 timer 0 control, 0x04 timer 1 control, 0x08 timer 0 reload, 0x0C timer 1 reload, 0x14 timer 1 live count, 0x18 event register. Any other offset reads zero.
- R3: The control word layout is as follows: bit 30 is run, bit 29 is interrupt enable, bits 28:27 are the mode, and bits 7:0 are the prescale value. All other bits read zero whatever was written to them.
- R4: A write that takes the run bit from 0 to 1 loads the counter with the reload value (up to 0xFFFFFF). The live count of timer 1 then decreases over time.
- R5: While running, the counter decrements once every (prescale + 1) clock cycles.
- R6: With mode bit 27 clear (single-shot), the tick that takes the count from 1 to 0 does three things: it sets the timer's event bit, it leaves the counter at 0, and it clears the run bit in hardware.
- R7: With mode bit 27 set (repeating), the tick that would reach zero sets the event bit and reloads the counter instead. A reload value of N therefore gives one event every N ticks, and the run bit stays set.
- R8: Writing the run bit to 0 freezes the count. Setting it again reloads the counter. A control write that leaves run at 1 changes the other fields without reloading.
- R9: In the event register, bit 0 belongs to timer 0 and bit 1 to timer 1. Writing a 1 to a bit clears it, and writing a 0 leaves it unchanged. If an event and a clear of the same bit fall in the same cycle, the event wins.
- R10: Each interrupt line is high exactly when that timer's event bit and its interrupt-enable bit are both set. The event bit is set even when the interrupt is disabled.
- R11: A reload-value write while the timer runs leaves the current count alone. The new value is used at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 5 | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 2 | Interrupt lines, bit i for timer i |

## Verification
A write presented in one cycle changes register contents at the edge that closes that cycle, and because reads are combinational the new value is visible on bus_rdata for the rest of the following cycle. Tick-driven results follow the same rule. A start edge shows the reload value straight away, the first decrement appears (prescale + 1) edges later, and the event bit and interrupt line rise in the cycle after the expiring tick. The bench's reference model advances on the same edge as the design. The bench compares read data and both interrupt lines at the falling edge, after every register has settled, for every cycle of the run.

// File: rtl/dntimer_pkg.sv
package dntimer_pkg;

   localparam int unsigned BUS_W = 32;

   // Register byte offsets (fixed map)
   localparam logic [7:0] OFS_CTL0  = 8'h00;
   localparam logic [7:0] OFS_CTL1  = 8'h04;
   localparam logic [7:0] OFS_RLD0  = 8'h08;
   localparam logic [7:0] OFS_RLD1  = 8'h0C;
   localparam logic [7:0] OFS_LIVE1 = 8'h14;
   localparam logic [7:0] OFS_EVT   = 8'h18;

   // Control word bit positions
   localparam int unsigned BIT_RUN  = 30;
   localparam int unsigned BIT_IEN  = 29;
   localparam int unsigned BIT_MHI  = 28;
   localparam int unsigned BIT_MLO  = 27;

   typedef enum logic [1:0] {
      MODE_SINGLE = 2'b00,
      MODE_REPEAT = 2'b01,
      MODE_RSV_A  = 2'b10,
      MODE_RSV_B  = 2'b11
   } tmode_e;

endpackage

// File: rtl/dntimer_presc.sv
module dntimer_presc #(
   parameter int unsigned PS_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic [PS_W-1:0] psc,
   output logic            tick
);

   logic [PS_W-1:0] div_q;

   // >= keeps the divider from wrapping when psc is lowered mid-count
   assign tick = run && (div_q >= psc);

   always_ff @(posedge clk) begin
      if (!rst_n)              div_q <= '0;
      else if (!run || tick)   div_q <= '0;
      else                     div_q <= div_q + 1'b1;
   end

   // R5: with a nonzero, unchanged divisor, two ticks are never adjacent
   a_r5_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && psc != '0) |=> (!tick || psc != $past(psc)));

endmodule

// File: rtl/dntimer_chan.sv
module dntimer_chan
   import dntimer_pkg::*;
#(
   parameter int unsigned CNT_W = 24,
   parameter int unsigned PS_W  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_wr,
   input  logic             rld_wr,
   input  logic             wr_run,
   input  logic             wr_ien,
   input  tmode_e           wr_mode,
   input  logic [PS_W-1:0]  wr_psc,
   input  logic [CNT_W-1:0] wr_rld,
   output logic [BUS_W-1:0] ctl_word,
   output logic [CNT_W-1:0] rld_val,
   output logic [CNT_W-1:0] cnt_val,
   output logic             ien,
   output logic             expire
);

   logic             run_q, ien_q;
   tmode_e           mode_q;
   logic [PS_W-1:0]  psc_q;
   logic [CNT_W-1:0] rld_q, cnt_q;
   logic             tick, start, repeat_m, at_end;

   dntimer_presc #(.PS_W(PS_W)) u_presc (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (run_q),
      .psc  (psc_q),
      .tick (tick)
   );

   assign start    = ctl_wr && wr_run && !run_q;
   assign repeat_m = mode_q[0];
   assign at_end   = (cnt_q <= CNT_W'(1));
   assign expire   = tick && at_end;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ien_q  <= 1'b0;
         mode_q <= MODE_SINGLE;
         psc_q  <= '0;
      end else if (ctl_wr) begin
         ien_q  <= wr_ien;
         mode_q <= wr_mode;
         psc_q  <= wr_psc;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                   run_q <= 1'b0;
      else if (ctl_wr)              run_q <= wr_run;
      else if (expire && !repeat_m) run_q <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       rld_q <= '0;
      else if (rld_wr)  rld_q <= wr_rld;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)          cnt_q <= '0;
      else if (start)      cnt_q <= rld_q;
      else if (tick) begin
         if (at_end)       cnt_q <= repeat_m ? rld_q : '0;
         else              cnt_q <= cnt_q - 1'b1;
      end
   end

   always_comb begin
      ctl_word                   = '0;
      ctl_word[BIT_RUN]          = run_q;
      ctl_word[BIT_IEN]          = ien_q;
      ctl_word[BIT_MHI:BIT_MLO]  = mode_q;
      ctl_word[PS_W-1:0]         = psc_q;
   end

   assign rld_val = rld_q;
   assign cnt_val = cnt_q;
   assign ien     = ien_q;

   // R4: a start edge loads the reload value
   a_r4_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (cnt_q == $past(rld_q) && run_q));

   // R6: single-shot expiry parks the counter at zero and stops it
   a_r6_single_stops: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && !repeat_m && !ctl_wr) |=> (!run_q && cnt_q == '0));

   // R7: repeating expiry reloads and keeps running
   a_r7_repeat_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && repeat_m && !ctl_wr) |=> (run_q && cnt_q == $past(rld_q)));

endmodule

// File: rtl/dntimer_evt.sv
module dntimer_evt #(
   parameter int unsigned N_T = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clr_wr,
   input  logic [N_T-1:0] clr_mask,
   input  logic [N_T-1:0] evt,
   input  logic [N_T-1:0] ien,
   output logic [N_T-1:0] flag,
   output logic [N_T-1:0] irq
);

   for (genvar gi = 0; gi < N_T; gi++) begin : g_bit
      logic flag_q;

      always_ff @(posedge clk) begin
         if (!rst_n)                        flag_q <= 1'b0;
         else if (evt[gi])                  flag_q <= 1'b1;
         else if (clr_wr && clr_mask[gi])   flag_q <= 1'b0;
      end

      assign flag[gi] = flag_q;
      assign irq[gi]  = flag_q & ien[gi];

      // R9: an event always lands, even against a clear
      a_r9_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
         evt[gi] |=> flag[gi]);

      // R9: writing one clears the bit when no event competes
      a_r9_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_wr && clr_mask[gi] && !evt[gi]) |=> !flag[gi]);
   end

endmodule

// File: rtl/dual_dntimer.sv
module dual_dntimer
   import dntimer_pkg::*;
#(
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned CNT_W  = 24,
   parameter int unsigned PS_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic [1:0]        irq
);

   localparam int unsigned N_T = 2;

   if (ADDR_W < 5 || ADDR_W > 8) begin : g_bad_addr
      $error("ADDR_W must lie in 5..8 to hold the register map");
   end
   if (CNT_W < 2 || CNT_W > BUS_W) begin : g_bad_cnt
      $error("CNT_W must lie in 2..32");
   end
   if (PS_W < 1 || PS_W > BIT_MLO) begin : g_bad_psc
      $error("PS_W must fit below the mode field");
   end

   localparam logic [ADDR_W-1:0] A_CTL0  = OFS_CTL0[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] A_CTL1  = OFS_CTL1[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] A_RLD0  = OFS_RLD0[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] A_RLD1  = OFS_RLD1[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] A_LIVE1 = OFS_LIVE1[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] A_EVT   = OFS_EVT[ADDR_W-1:0];

   logic [BUS_W-1:0] ctl_w  [N_T];
   logic [CNT_W-1:0] rld_w  [N_T];
   logic [CNT_W-1:0] cnt_w  [N_T];
   logic [N_T-1:0]   ien_w, exp_w, flag_w, ctl_wr, rld_wr;

   assign ctl_wr[0] = bus_we && (bus_addr == A_CTL0);
   assign ctl_wr[1] = bus_we && (bus_addr == A_CTL1);
   assign rld_wr[0] = bus_we && (bus_addr == A_RLD0);
   assign rld_wr[1] = bus_we && (bus_addr == A_RLD1);

   for (genvar gi = 0; gi < N_T; gi++) begin : g_tmr
      dntimer_chan #(.CNT_W(CNT_W), .PS_W(PS_W)) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .ctl_wr  (ctl_wr[gi]),
         .rld_wr  (rld_wr[gi]),
         .wr_run  (bus_wdata[BIT_RUN]),
         .wr_ien  (bus_wdata[BIT_IEN]),
         .wr_mode (tmode_e'(bus_wdata[BIT_MHI:BIT_MLO])),
         .wr_psc  (bus_wdata[PS_W-1:0]),
         .wr_rld  (bus_wdata[CNT_W-1:0]),
         .ctl_word(ctl_w[gi]),
         .rld_val (rld_w[gi]),
         .cnt_val (cnt_w[gi]),
         .ien     (ien_w[gi]),
         .expire  (exp_w[gi])
      );

      // R8: a stopped counter holds unless a start write arrives
      a_r8_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
         (!ctl_w[gi][BIT_RUN] && !(ctl_wr[gi] && bus_wdata[BIT_RUN]))
            |=> $stable(cnt_w[gi]));
   end

   dntimer_evt #(.N_T(N_T)) u_evt (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_wr  (bus_we && (bus_addr == A_EVT)),
      .clr_mask(bus_wdata[N_T-1:0]),
      .evt     (exp_w),
      .ien     (ien_w),
      .flag    (flag_w),
      .irq     (irq)
   );

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         A_CTL0:  bus_rdata = ctl_w[0];
         A_CTL1:  bus_rdata = ctl_w[1];
         A_RLD0:  bus_rdata[CNT_W-1:0] = rld_w[0];
         A_RLD1:  bus_rdata[CNT_W-1:0] = rld_w[1];
         A_LIVE1: bus_rdata[CNT_W-1:0] = cnt_w[1];
         A_EVT:   bus_rdata[N_T-1:0]   = flag_w;
         default: bus_rdata = '0;
      endcase
   end

   // R10: an interrupt line never rises without its enable
   a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq[1]) |-> ctl_w[1][BIT_IEN]);

endmodule

// File: tb/dual_dntimer_bench.sv
`timescale 1ns/1ps
module dual_dntimer_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [1:0]  irq;

   always #2 clk = ~clk;

   dual_dntimer u_dual_dntimer (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   localparam logic [31:0] RUN = 32'h4000_0000;
   localparam logic [31:0] IEN = 32'h2000_0000;
   localparam logic [31:0] REP = 32'h0800_0000;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;
   string phase = "R1";

   // reference model state
   int m_run[2], m_ien[2], m_mode[2], m_psc[2], m_rld[2], m_cnt[2], m_div[2];
   int m_evt;

   always @(posedge clk) begin
      int nevt, clr;
      if (!rst_n) begin
         for (int t = 0; t < 2; t++) begin
            m_run[t] = 0; m_ien[t] = 0; m_mode[t] = 0; m_psc[t] = 0;
            m_rld[t] = 0; m_cnt[t] = 0; m_div[t] = 0;
         end
         m_evt = 0;
      end else begin
         nevt = 0;
         for (int t = 0; t < 2; t++) begin
            bit tk, wc, wr, st, ex, rp;
            int ncnt, nrun;
            tk = (m_run[t] != 0) && (m_div[t] >= m_psc[t]);
            wc = bus_we && (bus_addr == (t == 0 ? 5'h00 : 5'h04));
            wr = bus_we && (bus_addr == (t == 0 ? 5'h08 : 5'h0C));
            st = wc && bus_wdata[30] && (m_run[t] == 0);
            ex = tk && (m_cnt[t] <= 1);
            rp = (m_mode[t] & 1) != 0;
            if (st) ncnt = m_rld[t];
            else if (tk) ncnt = (m_cnt[t] <= 1) ? (rp ? m_rld[t] : 0) : m_cnt[t] - 1;
            else ncnt = m_cnt[t];
            if (wc) nrun = bus_wdata[30];
            else if (ex && !rp) nrun = 0;
            else nrun = m_run[t];
            m_div[t] = (m_run[t] == 0 || tk) ? 0 : m_div[t] + 1;
            if (wc) begin
               m_ien[t]  = bus_wdata[29];
               m_mode[t] = bus_wdata[28:27];
               m_psc[t]  = bus_wdata[7:0];
            end
            if (wr) m_rld[t] = bus_wdata[23:0];
            m_cnt[t] = ncnt;
            m_run[t] = nrun;
            if (ex) nevt |= (1 << t);
         end
         clr = (bus_we && bus_addr == 5'h18) ? bus_wdata[1:0] : 0;
         m_evt = (m_evt & ~clr) | nevt;
      end
   end

   function automatic logic [31:0] ctl_of(int t);
      logic [31:0] w;
      w = '0;
      w[30] = m_run[t][0];
      w[29] = m_ien[t][0];
      w[28:27] = m_mode[t][1:0];
      w[7:0] = m_psc[t][7:0];
      return w;
   endfunction

   function automatic logic [31:0] model_read(logic [4:0] a);
      case (a)
         5'h00: return ctl_of(0);
         5'h04: return ctl_of(1);
         5'h08: return 32'(m_rld[0]);
         5'h0C: return 32'(m_rld[1]);
         5'h14: return 32'(m_cnt[1]);
         5'h18: return 32'(m_evt);
         default: return 32'h0;
      endcase
   endfunction

   task automatic compare();
      logic [31:0] er;
      logic [1:0]  ei;
      er = model_read(bus_addr);
      ei[0] = ((m_evt & 1) != 0) && (m_ien[0] != 0);
      ei[1] = ((m_evt & 2) != 0) && (m_ien[1] != 0);
      checks++;
      if (bus_rdata !== er) begin
         fails++;
         $display("FAIL %s rdata @%h: actual %h expected %h", phase, bus_addr, bus_rdata, er);
      end
      checks++;
      if (irq !== ei) begin
         fails++;
         $display("FAIL %s irq: actual %b expected %b", phase, irq, ei);
      end
   endtask

   task automatic step(input logic [4:0] a, input logic w, input logic [31:0] d);
      @(negedge clk);
      compare();
      bus_addr = a; bus_we = w; bus_wdata = d;
   endtask

   task automatic idle(input logic [4:0] a, input int n);
      for (int i = 0; i < n; i++) step(a, 1'b0, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset contents, every mapped offset
      phase = "R1";
      idle(5'h00, 1); idle(5'h04, 1); idle(5'h08, 1);
      idle(5'h0C, 1); idle(5'h14, 1); idle(5'h18, 1);

      // R2: unmapped offsets read zero
      phase = "R2";
      step(5'h08, 1'b1, 32'h0000_0005);
      idle(5'h10, 1); idle(5'h1C, 1); idle(5'h02, 1); idle(5'h08, 1);

      // R3: field layout and readback of control word
      phase = "R3";
      step(5'h04, 1'b1, IEN | REP | 32'd3);
      idle(5'h04, 2);
      step(5'h04, 1'b1, 32'hFFFF_FFFF & ~RUN);
      idle(5'h04, 2);
      step(5'h04, 1'b1, 32'h0);
      idle(5'h04, 1);

      // R4: start loads max reload; live count falls
      phase = "R4";
      step(5'h0C, 1'b1, 32'h00FF_FFFF);
      step(5'h04, 1'b1, RUN);
      idle(5'h14, 6);
      step(5'h04, 1'b1, 32'h0);
      idle(5'h14, 2);

      // R5: prescale of 2 gives a decrement every three cycles
      phase = "R5";
      step(5'h0C, 1'b1, 32'd20);
      step(5'h04, 1'b1, RUN | IEN | 32'd2);
      idle(5'h14, 40);

      // R6: single-shot expiry on timer 1
      phase = "R6";
      idle(5'h14, 25); idle(5'h04, 2); idle(5'h18, 2);

      // R9: write-one clear of timer 1 bit
      phase = "R9";
      step(5'h18, 1'b1, 32'h2);
      idle(5'h18, 3);

      // R7: repeating timer 0, interrupt disabled
      phase = "R7";
      step(5'h08, 1'b1, 32'd4);
      step(5'h00, 1'b1, RUN | REP);
      idle(5'h18, 10);
      step(5'h18, 1'b1, 32'h1);
      idle(5'h00, 10);

      // R11: reload change while running waits for next reload
      phase = "R11";
      step(5'h08, 1'b1, 32'd7);
      idle(5'h18, 3);
      step(5'h18, 1'b1, 32'h1);
      idle(5'h18, 20);

      // R10: enable interrupt on running timer 0 without restarting it
      phase = "R10";
      step(5'h00, 1'b1, RUN | REP | IEN);
      idle(5'h18, 12);
      step(5'h18, 1'b1, 32'h1);
      idle(5'h18, 5);

      // R8: halt and resume timer 1
      phase = "R8";
      step(5'h0C, 1'b1, 32'd50);
      step(5'h04, 1'b1, RUN | REP);
      idle(5'h14, 10);
      step(5'h04, 1'b1, REP);
      idle(5'h14, 10);
      step(5'h04, 1'b1, RUN | REP);
      idle(5'h14, 5);

      // R9: event every tick against repeated clears, set must win
      phase = "R9";
      step(5'h00, 1'b1, 32'h0);
      step(5'h08, 1'b1, 32'd1);
      step(5'h00, 1'b1, RUN | REP);
      idle(5'h18, 3);
      step(5'h18, 1'b1, 32'h1F);
      idle(5'h18, 2);
      step(5'h18, 1'b1, 32'h1F);
      idle(5'h18, 2);

      // R6: single-shot on timer 0 with prescale 1
      phase = "R6";
      step(5'h00, 1'b1, 32'h0);
      step(5'h18, 1'b1, 32'h3);
      step(5'h08, 1'b1, 32'd3);
      step(5'h00, 1'b1, RUN | IEN | 32'd1);
      idle(5'h00, 12);
      idle(5'h18, 2);
      step(5'h18, 1'b1, 32'h3);
      idle(5'h18, 3);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule